// File: doc/BRIEF.md
# Wake Event Holding Latch

This block sits beside a processor core that can enter a clock-stopped low-power state. Six kinds of event request reach it as single-cycle pulses: bus-init, init, system-management, two local interrupt lines (LINT1 and LINT0) and bus-delivered interrupts. Each pulse sets a pending flag. The flag stays set until the core's handler acknowledges it. While the core sleeps, nothing is passed on for service. Repeated pulses of one kind fold into a single pending occurrence.

When the sleep indicator drops, the block issues "service now" strobes to the core. It issues at most one per cycle, in a fixed priority order, and only once for each pending occurrence. While the core sleeps, a break-event output tells system logic that an interrupt is waiting and the core should be woken. This output ignores the interrupt-enable flag. That flag only holds back the service strobes of the interrupt-class events.

Top module: `wake_event_latch`

## Requirements
- R1: After reset, pendFlags, serviceStrobe and breakEvent are all zero.
- R2: A pulse on evtPulse[i] sets pendFlags[i] from the next cycle on, whether or not sleepState is high. Bit mapping: 0 bus-init, 1 init, 2 system-management, 3 LINT1, 4 LINT0, 5 bus interrupt.
- R3: No service strobe is issued in the cycle after one where sleepState was high.
- R4: Any number of pulses of one event, arriving before its acknowledge, yield exactly one service strobe for that event.
- R5: serviceStrobe is one-hot or zero. It selects the lowest-numbered pending event that has not yet been strobed and is eligible. It appears one cycle after the cycle in which sleepState is low and that event is pending.
- R6: ackIn[i] without a same-cycle pulse on evtPulse[i] clears pendFlags[i] from the next cycle.
- R7: A pulse on evtPulse[i] in the same cycle as ackIn[i] leaves pendFlags[i] set, and that event is strobed again as a new occurrence.
- R8: breakEvent equals sleepState AND (any of pendFlags[5:3] set), regardless of intEnable.
- R9: Pending bus-init, init or system-management events (bits 2:0) alone never raise breakEvent.
- R10: While intEnable is low, events 3 to 5 are not strobed. Events 0 to 2 are still strobed.
- R11: breakEvent is low whenever sleepState is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 6 | Single-cycle event request pulses, one bit per event |
| ackIn | input | 6 | Per-event service acknowledge, clears the pending flag |
| sleepState | input | 1 | High while the core is in the clock-stopped state |
| intEnable | input | 1 | Core interrupt-enable flag |
| pendFlags | output | 6 | Per-event pending flags |
| serviceStrobe | output | 6 | One-cycle service-now strobe, at most one bit set |
| breakEvent | output | 1 | Request to system logic to wake the core |

## Verification
The assertions check the following on every cycle: strobe one-hotness, silence of the strobes after a sleeping cycle, that every strobe is backed by a pending flag, flag set and clear on pulse and acknowledge, the interrupt-enable hold-back, and breakEvent staying low while awake. Some properties can only be shown by the bench's scenarios, which it checks against its reference model. These are that several pulses collapse into a single strobe, that strobes come out in the exact priority sequence after waking, and that a pulse landing on its own acknowledge is serviced a second time.

// File: rtl/wel_pkg.sv
package wel_pkg;
  localparam int NUM_EVT = 6;

  // Event slots; lower index means higher release priority
  localparam int IDX_BUSINIT = 0;
  localparam int IDX_INIT    = 1;
  localparam int IDX_SMGMT   = 2;
  localparam int IDX_LINT1   = 3;
  localparam int IDX_LINT0   = 4;
  localparam int IDX_BUSINT  = 5;

  // Events that count as interrupts (maskable, drive break-event)
  localparam logic [NUM_EVT-1:0] INT_CLASS =
    NUM_EVT'((1 << IDX_LINT1) | (1 << IDX_LINT0) | (1 << IDX_BUSINT));

  typedef struct packed {
    logic [NUM_EVT-1:0] grant;
  } wel_ctrl_t;
endpackage

// File: rtl/wel_control.sv
module wel_control
  import wel_pkg::*;
(
  input  logic [NUM_EVT-1:0] pendQ,
  input  logic [NUM_EVT-1:0] issuedQ,
  input  logic               sleepState,
  input  logic               intEnable,
  output wel_ctrl_t          ctrl
);
  logic [NUM_EVT-1:0] enableMask;
  logic [NUM_EVT-1:0] eligible;
  logic [NUM_EVT-1:0] taken;
  logic [NUM_EVT-1:0] grantVec;

  // Interrupt-class events wait for the enable flag; others never do
  assign enableMask = intEnable ? '1 : ~INT_CLASS;
  assign eligible   = sleepState ? '0 : (pendQ & ~issuedQ & enableMask);

  assign taken[0] = 1'b0;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_prio
    assign grantVec[g] = eligible[g] & ~taken[g];
    if (g < NUM_EVT - 1) begin : g_next
      assign taken[g+1] = taken[g] | eligible[g];
    end
  end

  assign ctrl.grant = grantVec;
endmodule

// File: rtl/wel_datapath.sv
module wel_datapath
  import wel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic [NUM_EVT-1:0] ackIn,
  input  logic               sleepState,
  input  wel_ctrl_t          ctrl,
  output logic [NUM_EVT-1:0] pendQ,
  output logic [NUM_EVT-1:0] issuedQ,
  output logic [NUM_EVT-1:0] strobeQ,
  output logic               breakEvent
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      issuedQ <= '0;
      strobeQ <= '0;
    end else begin
      // A fresh pulse wins over its own acknowledge
      pendQ   <= (pendQ & ~ackIn) | evtPulse;
      // Acknowledge ends an occurrence, so it re-arms the strobe
      issuedQ <= (issuedQ | ctrl.grant) & ~ackIn;
      strobeQ <= ctrl.grant;
    end
  end

  assign breakEvent = sleepState & (|(pendQ & INT_CLASS));
endmodule

// File: rtl/wake_event_latch.sv
module wake_event_latch
  import wel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic [NUM_EVT-1:0] ackIn,
  input  logic               sleepState,
  input  logic               intEnable,
  output logic [NUM_EVT-1:0] pendFlags,
  output logic [NUM_EVT-1:0] serviceStrobe,
  output logic               breakEvent
);
  wel_ctrl_t          ctrl;
  logic [NUM_EVT-1:0] pendQ;
  logic [NUM_EVT-1:0] issuedQ;

  wel_control u_ctrl (
    .pendQ      (pendQ),
    .issuedQ    (issuedQ),
    .sleepState (sleepState),
    .intEnable  (intEnable),
    .ctrl       (ctrl)
  );

  wel_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .evtPulse   (evtPulse),
    .ackIn      (ackIn),
    .sleepState (sleepState),
    .ctrl       (ctrl),
    .pendQ      (pendQ),
    .issuedQ    (issuedQ),
    .strobeQ    (serviceStrobe),
    .breakEvent (breakEvent)
  );

  assign pendFlags = pendQ;
endmodule

// File: rtl/wake_event_latch_chk.sv
module wake_event_latch_chk
  import wel_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtPulse,
  input logic [NUM_EVT-1:0] ackIn,
  input logic               sleepState,
  input logic               intEnable,
  input logic [NUM_EVT-1:0] pendFlags,
  input logic [NUM_EVT-1:0] serviceStrobe,
  input logic               breakEvent
);
  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(serviceStrobe));

  // R3
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepState |=> (serviceStrobe == '0));

  // R5
  strobe_backed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serviceStrobe != '0) |-> (($past(pendFlags) & serviceStrobe) == serviceStrobe));

  // R2
  pulse_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((pendFlags & $past(evtPulse)) == $past(evtPulse)));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ackIn & ~evtPulse) != '0) |=> ((pendFlags & $past(ackIn & ~evtPulse)) == '0));

  // R10
  int_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |=> ((serviceStrobe & INT_CLASS) == '0));

  // R11
  awake_nobreak_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sleepState |-> !breakEvent);
endmodule

bind wake_event_latch wake_event_latch_chk u_chk (.*);

// File: tb/wake_event_latch_tb.sv
`timescale 1ns/1ps
module wake_event_latch_tb;
  localparam logic [5:0] MASK_INT = 6'b111000;

  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] evtPulse, ackIn;
  logic       sleepState, intEnable;
  logic [5:0] pendFlags, serviceStrobe;
  logic       breakEvent;

  int errors = 0;
  int checks = 0;
  logic [5:0] mPend = '0, mIss = '0, mStrobe = '0;
  int order[$];
  int strobeCount[6];

  always #2 clk = ~clk;

  wake_event_latch u_dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .ackIn(ackIn),
    .sleepState(sleepState), .intEnable(intEnable),
    .pendFlags(pendFlags), .serviceStrobe(serviceStrobe), .breakEvent(breakEvent)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    int pick;
    logic [5:0] nextStrobe;
    if (!rstN) begin
      mPend = '0; mIss = '0; mStrobe = '0;
    end else begin
      pick = -1;
      nextStrobe = '0;
      if (!sleepState)
        for (int i = 0; i < 6; i++)
          if (pick < 0 && mPend[i] && !mIss[i] && (intEnable || !MASK_INT[i]))
            pick = i;
      if (pick >= 0) nextStrobe[pick] = 1'b1;
      for (int i = 0; i < 6; i++) begin
        if (ackIn[i]) mIss[i] = 1'b0;
        else if (nextStrobe[i]) mIss[i] = 1'b1;
        if (evtPulse[i]) mPend[i] = 1'b1;
        else if (ackIn[i]) mPend[i] = 1'b0;
      end
      mStrobe = nextStrobe;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic expBreak;
    @(posedge clk);
    @(negedge clk);
    expBreak = sleepState & (|(mPend & MASK_INT));
    check(pendFlags === mPend, "R2 pending flags vs model", pendFlags, mPend);
    check(serviceStrobe === mStrobe, "R5 strobe vs model", serviceStrobe, mStrobe);
    check(breakEvent === expBreak, "R8 break-event vs model", breakEvent, expBreak);
    for (int i = 0; i < 6; i++)
      if (serviceStrobe[i]) begin
        order.push_back(i);
        strobeCount[i]++;
      end
  endtask

  task automatic step(input logic [5:0] e, input logic [5:0] a);
    evtPulse = e; ackIn = a;
    tick();
    evtPulse = '0; ackIn = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) strobeCount[i] = 0;
    rstN = 1'b0; evtPulse = '0; ackIn = '0; sleepState = 1'b0; intEnable = 1'b1;
    idle(3);
    // R1
    check(pendFlags == '0 && serviceStrobe == '0 && breakEvent == 1'b0,
          "R1 reset state", {pendFlags, serviceStrobe, breakEvent}, 0);
    rstN = 1'b1;
    idle(1);

    // Asleep: repeated pulses collapse, nothing strobed
    sleepState = 1'b1;
    step(6'b000100, '0);
    step(6'b010100, '0);
    step(6'b100100, '0);
    step(6'b010010, '0);
    idle(2);
    check(pendFlags == 6'b110110, "R2 flags after sleeping pulses", pendFlags, 6'b110110);
    check(order.size() == 0, "R3 no strobe while asleep", order.size(), 0);
    check(breakEvent == 1'b1, "R8 break with interrupts pending", breakEvent, 1);
    intEnable = 1'b0;
    idle(1);
    check(breakEvent == 1'b1, "R8 break ignores interrupt-enable", breakEvent, 1);

    // Wake with interrupts masked
    sleepState = 1'b0;
    idle(4);
    check(order.size() == 2 && order[0] == 1 && order[1] == 2,
          "R10 only non-interrupt events strobed", order.size(), 2);
    check(breakEvent == 1'b0, "R11 break low while awake", breakEvent, 0);

    step('0, 6'b000110);
    intEnable = 1'b1;
    idle(4);
    check(order.size() == 4 && order[2] == 4 && order[3] == 5,
          "R5 priority order LINT0 then bus interrupt", order.size(), 4);
    check(strobeCount[2] == 1, "R4 three pulses give one strobe", strobeCount[2], 1);

    step('0, 6'b111111);
    idle(1);
    check(pendFlags == '0, "R6 acknowledge clears flags", pendFlags, 0);

    // Non-interrupt events only: no break-event
    sleepState = 1'b1;
    step(6'b000111, '0);
    idle(1);
    check(breakEvent == 1'b0, "R9 no break for bits 2:0", breakEvent, 0);
    check(pendFlags == 6'b000111, "R2 flags for bits 2:0", pendFlags, 6'b000111);
    order.delete();
    sleepState = 1'b0;
    idle(4);
    check(order.size() == 3 && order[0] == 0 && order[1] == 1 && order[2] == 2,
          "R5 priority bus-init, init, system-management", order.size(), 3);

    // Pulse on the acknowledge cycle keeps the flag and re-strobes
    step(6'b000100, 6'b000100);
    check(pendFlags[2] == 1'b1, "R7 flag survives own acknowledge", pendFlags[2], 1);
    idle(3);
    check(strobeCount[2] == 3, "R7 new occurrence strobed again", strobeCount[2], 3);

    step('0, 6'b111111);
    idle(2);
    check(pendFlags == '0 && serviceStrobe == '0, "R6 final clear", pendFlags, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule